// File: doc/BRIEF.md
# Float-to-Integer Converter

This block takes one single-precision floating-point value and turns it into a signed 32-bit two's-complement integer. A two-bit rounding mode goes in with each operand and decides how a value with a fractional part is resolved. Every result comes with two status flags: `invalid` reports that no representable integer exists, and `inexact` reports that a nonzero fraction was dropped.

Any input that has no integer equivalent gives the single fixed sentinel `0x80000000` and never a saturated bound. This covers NaN, both infinities and finite values whose rounded magnitude is out of range. The flags describe this one conversion only; nothing is kept from one operation to the next. By default the result is registered, so it appears one clock after the operand is accepted. A parameter can make the datapath purely combinational instead. The field widths are parameters, and their default values give the single-precision to 32-bit case.

Top module: `flt2int_cvt`

## Requirements
- R1: A finite input whose rounded value fits in a signed 32-bit integer returns that value, rounded by `in_rmode`: 00 = nearest with ties to even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero. A nonzero result has the sign of the input.
- R2: In mode 00, an input lying exactly halfway between two integers goes to the even integer (2.5 gives 2, -1.5 gives -2).
- R3: A NaN or an infinity (exponent field bits 30:23 all ones) returns `0x80000000` with `out_invalid` = 1 and `out_inexact` = 0, in every mode.
- R4: A finite input whose rounded value is above 2^31-1 or below -2^31 returns `0x80000000` with `out_invalid` = 1 and `out_inexact` = 0.
- R5: The input -2^31 (`0xCF000000`) returns `0x80000000` with `out_invalid` = 0 and `out_inexact` = 0.
- R6: Positive and negative zero both return 0 with both flags clear.
- R7: A denormal input (exponent field zero, fraction nonzero) or any nonzero input with magnitude below 1 returns 0, 1 or -1, as set by the mode and the sign, and sets `out_inexact`. In mode 11 the result is always 0.
- R8: `out_inexact` is 1 exactly when the input had a nonzero fraction that was discarded and the result is not invalid. It is never set together with `out_invalid`.
- R9: With the default registered output, `out_valid` follows `in_valid` one clock later, and the result and flags belong to the operand accepted on that edge. They hold when no new operand arrives. Reset clears `out_valid`, `out_int` and both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_value | input | 32 | Single-precision operand |
| in_rmode | input | 2 | Rounding mode (encoding in R1) |
| out_valid | output | 1 | Result present |
| out_int | output | 32 | Signed integer result |
| out_invalid | output | 1 | No representable integer exists |
| out_inexact | output | 1 | A nonzero fraction was dropped |

## Verification
The bound checker tests these properties on every result:
- the sentinel value whenever `invalid` is raised;
- the two flags never set together;
- NaN and infinity handling;
- zero giving zero;
- denormals staying within {-1, 0, 1};
- the sign of every valid nonzero result;
- the one-cycle relation between `in_valid` and `out_valid`.

Only the bench's scenarios can show that the value is correct. It compares every result against an arithmetic model in all four modes. The inputs are swept over every exponent with chosen fraction patterns, including exact ties and near-ties. It also uses random operands and the edges around ±2^31.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_DOWN    = 2'b01,
      RM_UP      = 2'b10,
      RM_ZERO    = 2'b11
   } rmode_e;
endpackage

// File: rtl/cvt_classify.sv
module cvt_classify #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int VAL_W = 1 + EXP_W + MAN_W
) (
   input  logic [VAL_W-1:0]        val,
   output logic                    sign,
   output logic                    is_special,
   output logic                    is_zero_exp,
   output logic [MAN_W:0]          sig,
   output logic signed [EXP_W+1:0] uexp
);
   localparam logic [EXP_W+1:0] BIAS = (EXP_W+2)'((1 << (EXP_W-1)) - 1);

   logic [EXP_W-1:0] expf;
   logic [MAN_W-1:0] manf;

   always_comb begin
      sign        = val[VAL_W-1];
      expf        = val[VAL_W-2 -: EXP_W];
      manf        = val[MAN_W-1:0];
      is_special  = &expf;
      is_zero_exp = (expf == '0);
      sig         = {~is_zero_exp, manf};
      uexp        = $signed({2'b00, expf} - BIAS);
   end
endmodule

// File: rtl/cvt_align.sv
module cvt_align #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int INT_W = 32
) (
   input  logic [MAN_W:0]          sig,
   input  logic signed [EXP_W+1:0] uexp,
   input  logic                    is_zero_exp,
   input  logic                    is_special,
   output logic [INT_W-1:0]        mag,
   output logic                    rnd,
   output logic                    stk,
   output logic                    big
);
   localparam int SH_W = MAN_W + INT_W;
   localparam int SA_W = $clog2(INT_W);
   localparam logic signed [EXP_W+1:0] INT_LIM = (EXP_W+2)'(INT_W);

   logic [SH_W-1:0] prod;

   always_comb begin
      mag  = '0;
      rnd  = 1'b0;
      stk  = 1'b0;
      big  = 1'b0;
      prod = '0;
      if (is_special) begin
         big = 1'b0;
      end else if (is_zero_exp) begin
         stk = |sig[MAN_W-1:0];
      end else if (uexp[EXP_W+1]) begin
         if (uexp == '1) begin
            rnd = 1'b1;
            stk = |sig[MAN_W-1:0];
         end else begin
            stk = 1'b1;
         end
      end else if (uexp >= INT_LIM) begin
         big = 1'b1;
      end else begin
         prod = {{(SH_W-MAN_W-1){1'b0}}, sig} << uexp[SA_W-1:0];
         mag  = prod[MAN_W +: INT_W];
         rnd  = prod[MAN_W-1];
         stk  = |prod[MAN_W-2:0];
      end
   end
endmodule

// File: rtl/cvt_round.sv
module cvt_round
   import cvt_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  logic             sign,
   input  logic [INT_W-1:0] mag,
   input  logic             rnd,
   input  logic             stk,
   input  logic             big,
   input  logic             special,
   input  rmode_e           rmode,
   output logic [INT_W-1:0] res,
   output logic             invalid,
   output logic             inexact
);
   localparam logic [INT_W:0]   LIMIT = (INT_W+1)'(1) << (INT_W-1);
   localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

   logic             inc;
   logic             ovf;
   logic [INT_W:0]   mag_r;
   logic [INT_W-1:0] signed_v;

   always_comb begin
      unique case (rmode)
         RM_NEAREST: inc = rnd & (stk | mag[0]);
         RM_DOWN:    inc = (rnd | stk) & sign;
         RM_UP:      inc = (rnd | stk) & ~sign;
         default:    inc = 1'b0;
      endcase
      mag_r    = {1'b0, mag} + (INT_W+1)'(inc);
      ovf      = sign ? (mag_r > LIMIT) : (mag_r >= LIMIT);
      invalid  = special | big | ovf;
      signed_v = sign ? (~mag_r[INT_W-1:0] + 1'b1) : mag_r[INT_W-1:0];
      res      = invalid ? INDEF : signed_v;
      inexact  = (rnd | stk) & ~invalid;
   end
endmodule

// File: rtl/flt2int_cvt.sv
module flt2int_cvt
   import cvt_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter int INT_W   = 32,
   parameter bit REG_OUT = 1'b1,
   localparam int VAL_W  = 1 + EXP_W + MAN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VAL_W-1:0] in_value,
   input  logic [1:0]       in_rmode,
   output logic             out_valid,
   output logic [INT_W-1:0] out_int,
   output logic             out_invalid,
   output logic             out_inexact
);
   generate
      if (EXP_W < 2 || MAN_W < 2 || INT_W < 2 || (EXP_W + 2) < $clog2(INT_W)) begin : g_bad_cfg
         $error("flt2int_cvt: unsupported width parameters");
      end
   endgenerate

   logic                    c_sign, c_special, c_zexp;
   logic [MAN_W:0]          c_sig;
   logic signed [EXP_W+1:0] c_uexp;
   logic [INT_W-1:0]        a_mag;
   logic                    a_rnd, a_stk, a_big;
   logic [INT_W-1:0]        r_res;
   logic                    r_inv, r_inx;

   cvt_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
      .val(in_value), .sign(c_sign), .is_special(c_special),
      .is_zero_exp(c_zexp), .sig(c_sig), .uexp(c_uexp)
   );

   cvt_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
      .sig(c_sig), .uexp(c_uexp), .is_zero_exp(c_zexp), .is_special(c_special),
      .mag(a_mag), .rnd(a_rnd), .stk(a_stk), .big(a_big)
   );

   cvt_round #(.INT_W(INT_W)) u_round (
      .sign(c_sign), .mag(a_mag), .rnd(a_rnd), .stk(a_stk), .big(a_big),
      .special(c_special), .rmode(rmode_e'(in_rmode)),
      .res(r_res), .invalid(r_inv), .inexact(r_inx)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid   <= 1'b0;
               out_int     <= '0;
               out_invalid <= 1'b0;
               out_inexact <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_int     <= r_res;
                  out_invalid <= r_inv;
                  out_inexact <= r_inx;
               end
            end
         end
      end else begin : g_comb
         assign out_valid   = in_valid;
         assign out_int     = r_res;
         assign out_invalid = r_inv;
         assign out_inexact = r_inx;
      end
   endgenerate
endmodule

// File: rtl/cvt_checker.sv
module cvt_checker #(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter int INT_W   = 32,
   parameter bit REG_OUT = 1'b1,
   localparam int VAL_W  = 1 + EXP_W + MAN_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [VAL_W-1:0] in_value,
   input logic [1:0]       in_rmode,
   input logic             out_valid,
   input logic [INT_W-1:0] out_int,
   input logic             out_invalid,
   input logic             out_inexact
);
   localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

   logic             v_q;
   logic [VAL_W-1:0] val_q;
   logic [1:0]       mode_q;

   generate
      if (REG_OUT) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q    <= 1'b0;
               val_q  <= '0;
               mode_q <= 2'b00;
            end else begin
               v_q    <= in_valid;
               val_q  <= in_value;
               mode_q <= in_rmode;
            end
         end
      end else begin : g_nodly
         assign v_q    = in_valid;
         assign val_q  = in_value;
         assign mode_q = in_rmode;
      end
   endgenerate

   logic [EXP_W-1:0] exp_q;
   logic [MAN_W-1:0] man_q;
   assign exp_q = val_q[VAL_W-2 -: EXP_W];
   assign man_q = val_q[MAN_W-1:0];

   AST_INDEF_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_invalid |-> out_int == INDEF);                            // R4
   AST_FLAGS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_invalid && out_inexact));                              // R8
   AST_NAN_INF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      v_q && (&exp_q) |-> out_invalid && !out_inexact && out_int == INDEF);      // R3
   AST_ZERO_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      v_q && exp_q == '0 && man_q == '0 |-> out_int == '0 && !out_invalid && !out_inexact); // R6
   AST_TINY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      v_q && exp_q == '0 && man_q != '0 |-> out_inexact && (out_int == '0 || out_int == INT_W'(1) || out_int == '1)); // R7
   AST_TINY_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
      v_q && exp_q == '0 && mode_q == 2'b11 |-> out_int == '0);                  // R7
   AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      v_q && !out_invalid && out_int != '0 |-> out_int[INT_W-1] == val_q[VAL_W-1]); // R1
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v_q);                                                         // R9
endmodule

bind flt2int_cvt cvt_checker #(
   .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .REG_OUT(REG_OUT)
) i_chk (.*);

// File: tb/test_flt2int_cvt.sv
module test_flt2int_cvt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_value = '0;
   logic [1:0]  in_rmode = 2'b00;
   logic        out_valid;
   logic [31:0] out_int;
   logic        out_invalid;
   logic        out_inexact;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 20 ns period, 50 MHz

   flt2int_cvt i_flt2int_cvt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
      .in_rmode(in_rmode), .out_valid(out_valid), .out_int(out_int),
      .out_invalid(out_invalid), .out_inexact(out_inexact)
   );

   task automatic ref_model(input logic [31:0] b, input logic [1:0] m,
                            output logic [31:0] r, output logic inv,
                            output logic inx, output string tag);
      int  e;
      real x, fl, fr, q;
      e = int'(b[30:23]);
      if (e == 255) begin
         r = 32'h8000_0000; inv = 1'b1; inx = 1'b0; tag = "R3";
         return;
      end
      if (e == 0) x = real'(b[22:0]) * (2.0 ** (-149));
      else        x = (8388608.0 + real'(b[22:0])) * (2.0 ** (e - 150));
      if (b[31]) x = -x;
      fl = $floor(x);
      fr = x - fl;
      case (m)
         2'd0: begin
            if (fr > 0.5)      q = fl + 1.0;
            else if (fr < 0.5) q = fl;
            else               q = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
         end
         2'd1:    q = fl;
         2'd2:    q = $ceil(x);
         default: q = (x < 0.0) ? $ceil(x) : fl;
      endcase
      if (q > 2147483647.0 || q < -2147483648.0) begin
         r = 32'h8000_0000; inv = 1'b1; inx = 1'b0; tag = "R4";
         return;
      end
      r   = 32'(longint'(q));
      inv = 1'b0;
      inx = (q != x);
      if (b == 32'hCF00_0000)                 tag = "R5";
      else if (x == 0.0)                      tag = "R6";
      else if (x < 1.0 && x > -1.0)           tag = "R7";
      else if (m == 2'd0 && fr == 0.5)        tag = "R2";
      else                                    tag = "R1";
   endtask

   // drive one operand at a falling edge, check it at the next falling edge
   task automatic run_vec(input logic [31:0] b, input logic [1:0] m);
      logic [31:0] er;
      logic        ei, ex;
      string       tag;
      in_value = b;
      in_rmode = m;
      in_valid = 1'b1;
      @(negedge clk);
      ref_model(b, m, er, ei, ex, tag);
      n_run++;
      if (!out_valid || out_int !== er || out_invalid !== ei) begin
         n_fail++;
         $display("FAIL %s in=%h mode=%0d got=%h inv=%b vld=%b exp=%h inv=%b vld=1",
                  tag, b, m, out_int, out_invalid, out_valid, er, ei);
      end
      n_run++;
      if (out_inexact !== ex) begin   // R8
         n_fail++;
         $display("FAIL R8 in=%h mode=%0d got inexact=%b exp inexact=%b", b, m, out_inexact, ex);
      end
   endtask

   function automatic logic [22:0] frac_pat(input int p);
      case (p)
         0: return 23'h000000;
         1: return 23'h000001;
         2: return 23'h400000;
         3: return 23'h400001;
         4: return 23'h3FFFFF;
         5: return 23'h7FFFFF;
         6: return 23'h200000;
         default: return 23'h600000;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog: got=still running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] lf;
      logic [31:0] last;
      logic [31:0] edges [12];
      edges = '{32'hCF00_0000, 32'h4F00_0000, 32'h4EFF_FFFF, 32'hCF00_0001,
                32'h3F00_0000, 32'h3FC0_0000, 32'h4020_0000, 32'h8000_0000,
                32'h0000_0001, 32'h807F_FFFF, 32'h7FC0_0000, 32'hBFC0_0000};
      repeat (3) @(negedge clk);
      n_run++;   // R9 reset state
      if (out_valid !== 1'b0 || out_int !== 32'h0 || out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
         n_fail++;
         $display("FAIL R9 reset got=%b/%h/%b/%b exp=0/00000000/0/0",
                  out_valid, out_int, out_invalid, out_inexact);
      end
      rst_n = 1'b1;
      @(negedge clk);

      foreach (edges[k]) begin
         for (int m = 0; m < 4; m++) run_vec(edges[k], 2'(m));
      end

      for (int e = 0; e < 256; e++) begin
         for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 2; s++) begin
               for (int m = 0; m < 4; m++) begin
                  run_vec({1'(s), 8'(e), frac_pat(p)}, 2'(m));
               end
            end
         end
      end

      lf = 32'h1ACE_B00C;
      for (int n = 0; n < 3000; n++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         for (int m = 0; m < 4; m++) run_vec(lf, 2'(m));
      end

      // R9: out_valid drops one cycle after in_valid, result holds
      last = out_int;
      in_valid = 1'b0;
      in_value = 32'h4120_0000;
      @(negedge clk);
      n_run++;
      if (out_valid !== 1'b0 || out_int !== last) begin
         n_fail++;
         $display("FAIL R9 idle got=%b/%h exp=0/%h", out_valid, out_int, last);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule